// File: doc/BRIEF.md
# Hierarchical Soft-Reset Sequencer

This block sequences software-commanded resets inside a packet-switching subsystem. The subsystem has three child units (two Ethernet port engines and one DMA engine) and a shared core group (interrupt logic, register file, descriptor interface and packet buffering). Software writes a one into a unit's reset word. The sequencer raises a level request toward that unit and holds it until the unit answers with a one-cycle completion pulse. While the request is outstanding, the word reads back as one. Once the unit has answered, it reads zero again, so software can poll it.

The core group reset is the last step of a full subsystem reset. The sequencer remembers, per child, that a reset has finished since the last core reset. It launches the core reset only when all three children have finished. The children may be launched and may complete in any order. A core write that comes too early is dropped and raises an error bit. An asynchronous active-low reset clears the whole sequencer at once. Its release is synchronized to the clock.

Top module: `srst_seq`

## Requirements
- R1: The reset word of each target is selected by address bits [3:2]: 0 is port engine A, 1 is port engine B, 2 is the DMA engine, 3 is the core group. Bit 0 of every word is the reset bit. Bit 1 of the core word is the error flag. All other bits read zero. After reset every word reads zero and every request output is low.
- R2: Writing a word with bit 0 set to an idle child sets its reset bit and raises its request output from the next clock. A write with bit 0 clear changes nothing.
- R3: A request stays high and its reset bit reads one until the target's done input is sampled high. Both fall on the clock edge that samples the done pulse.
- R4: Writing one to a target that is already busy is ignored. The sequence is not restarted, and the target's first done pulse still ends it.
- R5: The three child resets are independent. They may be launched and may complete in any order, including overlapping each other.
- R6: A done pulse from a target that has no reset outstanding changes nothing and does not count as a completed reset.
- R7: A core write with bit 0 set is accepted only when each of the three children has completed a reset since the last core completion. An accepted write drives the core request and reset bit as in R2 and R3.
- R8: A core write with bit 0 set that arrives while any child has not completed is dropped and sets the error flag. The error flag stays set until a later core write is accepted, which clears it.
- R9: Completion of the core reset forgets all child completions. A new core write is therefore rejected until all three children are reset again.
- R10: Driving the reset input low clears every reset bit, completion record and the error flag, and drops every request output at once, without waiting for a clock. Writes are acted on again from the third clock edge after the reset input returns high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe, one write per cycle it is high |
| bus_addr | input | 4 | Byte address of the word being written or read |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| child_req | output | 3 | Reset request to each child (0 port A, 1 port B, 2 DMA) |
| child_done | input | 3 | One-cycle completion pulse from each child |
| core_req | output | 1 | Reset request to the core group |
| core_done | input | 1 | One-cycle completion pulse from the core group |

## Verification
A wrong busy bit appears on the matching request output and in the readback on the same clock edge. A stale or missing completion record stays invisible until the next core write. At that point it shows up as a core request that should not have risen, or as an error flag where none was due. The bench therefore compares every output with a behavioural model on every cycle. It also ends its sequences with core writes that expose the completion records. Targets with random latencies exercise the any-order and overlapping paths.

// File: rtl/srst_pkg.sv
`timescale 1ns/1ps
package srst_pkg;
  // Bit positions inside every reset word
  localparam int unsigned GO_BIT  = 0;
  localparam int unsigned ERR_BIT = 1;
  // Byte offset bits below the word select
  localparam int unsigned BYTE_BITS = 2;
  // Synchronizer depth for reset release
  localparam int unsigned RST_STAGES = 2;
endpackage

// File: rtl/srst_rst_sync.sv
`timescale 1ns/1ps
module srst_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_q_n
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign rst_q_n = sync_q[STAGES-1];
endmodule

// File: rtl/srst_chan.sv
`timescale 1ns/1ps
module srst_chan (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic done,
  output logic busy,
  output logic fin
);
  logic busy_q;
  logic busy_d;
  logic busy_en;

  always_comb begin
    busy_en = 1'b0;
    busy_d  = busy_q;
    if (busy_q) begin
      if (done) begin
        busy_en = 1'b1;
        busy_d  = 1'b0;
      end
    end else if (start) begin
      busy_en = 1'b1;
      busy_d  = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
    end else if (busy_en) begin
      busy_q <= busy_d;
    end
  end

  assign busy = busy_q;
  assign fin  = busy_q & done;

  // R3: request held until the done pulse, dropped right after it
  assert_hold_until_done_R3: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !done |=> busy);
  assert_drop_after_done_R3: assert property (@(posedge clk) disable iff (!rst_n)
    busy && done |=> !busy);
  // R2: a launch shows up on the next edge
  assert_launch_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !busy && start |=> busy);
  // R6: without a launch an idle target stays idle, whatever done does
  assert_idle_stays_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !busy && !start |=> !busy);
endmodule

// File: rtl/srst_gate.sv
`timescale 1ns/1ps
module srst_gate #(
  parameter int unsigned N_CHILD = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [N_CHILD-1:0] child_fin,
  input  logic               core_fin,
  input  logic               core_try,
  output logic               core_accept,
  output logic               all_done,
  output logic               err
);
  logic [N_CHILD-1:0] seen_q;
  logic [N_CHILD-1:0] seen_d;
  logic               seen_en;
  logic               err_q;
  logic               err_d;
  logic               err_en;

  assign all_done    = &seen_q;
  assign core_accept = core_try & all_done;

  always_comb begin
    seen_en = core_fin | (|child_fin);
    if (core_fin) begin
      seen_d = '0;
    end else begin
      seen_d = seen_q | child_fin;
    end
  end

  always_comb begin
    err_en = core_try;
    err_d  = err_q;
    if (core_try) begin
      err_d = ~all_done;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seen_q <= '0;
    end else if (seen_en) begin
      seen_q <= seen_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      err_q <= 1'b0;
    end else if (err_en) begin
      err_q <= err_d;
    end
  end

  assign err = err_q;

  // R9: core completion wipes every child record
  assert_forget_on_core_R9: assert property (@(posedge clk) disable iff (!rst_n)
    core_fin |=> seen_q == '0);
  // R8: an early core write raises the error flag, an accepted one clears it
  assert_reject_flags_R8: assert property (@(posedge clk) disable iff (!rst_n)
    core_try && !all_done |=> err);
  assert_accept_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
    core_accept |=> !err);

  generate
    for (genvar g = 0; g < N_CHILD; g++) begin : g_sticky
      // R5: a child record, once set, survives until core completion
      assert_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
        seen_q[g] && !core_fin |=> seen_q[g]);
    end
  endgenerate
endmodule

// File: rtl/srst_seq.sv
`timescale 1ns/1ps
module srst_seq #(
  parameter int unsigned N_CHILD = 3,
  parameter int unsigned DATA_W  = 32,
  localparam int unsigned N_SLOT = N_CHILD + 1,
  localparam int unsigned SEL_W  = $clog2(N_SLOT),
  localparam int unsigned ADDR_W = SEL_W + srst_pkg::BYTE_BITS
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               bus_wr,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic [DATA_W-1:0]  bus_wdata,
  output logic [DATA_W-1:0]  bus_rdata,
  output logic [N_CHILD-1:0] child_req,
  input  logic [N_CHILD-1:0] child_done,
  output logic               core_req,
  input  logic               core_done
);
  import srst_pkg::*;

  logic              rst_q_n;
  logic [SEL_W-1:0]  slot_sel;
  logic [N_SLOT-1:0] wr_go;
  logic [N_SLOT-1:0] start_v;
  logic [N_SLOT-1:0] done_v;
  logic [N_SLOT-1:0] busy_v;
  logic [N_SLOT-1:0] fin_v;
  logic              core_try;
  logic              core_accept;
  logic              all_done;
  logic              err;
  logic              unused_bits;

  srst_rst_sync #(.STAGES(RST_STAGES)) i_rst_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .rst_q_n (rst_q_n)
  );

  assign slot_sel    = bus_addr[ADDR_W-1:BYTE_BITS];
  assign unused_bits = ^{bus_addr[BYTE_BITS-1:0], bus_wdata[DATA_W-1:1]};

  always_comb begin
    for (int s = 0; s < N_SLOT; s++) begin
      wr_go[s] = bus_wr & bus_wdata[GO_BIT] & (int'(slot_sel) == s);
    end
  end

  assign done_v   = {core_done, child_done};
  assign core_try = wr_go[N_CHILD] & ~busy_v[N_CHILD];

  generate
    for (genvar g = 0; g < N_SLOT; g++) begin : g_chan
      if (g < N_CHILD) begin : g_child
        assign start_v[g] = wr_go[g];
      end else begin : g_core
        assign start_v[g] = core_accept;
      end
      srst_chan i_chan (
        .clk   (clk),
        .rst_n (rst_q_n),
        .start (start_v[g]),
        .done  (done_v[g]),
        .busy  (busy_v[g]),
        .fin   (fin_v[g])
      );
    end
  endgenerate

  srst_gate #(.N_CHILD(N_CHILD)) i_gate (
    .clk         (clk),
    .rst_n       (rst_q_n),
    .child_fin   (fin_v[N_CHILD-1:0]),
    .core_fin    (fin_v[N_CHILD]),
    .core_try    (core_try),
    .core_accept (core_accept),
    .all_done    (all_done),
    .err         (err)
  );

  always_comb begin
    bus_rdata = '0;
    for (int s = 0; s < N_SLOT; s++) begin
      if (int'(slot_sel) == s) begin
        bus_rdata[GO_BIT] = busy_v[s];
        if (s == N_CHILD) begin
          bus_rdata[ERR_BIT] = err;
        end
      end
    end
  end

  assign child_req = busy_v[N_CHILD-1:0];
  assign core_req  = busy_v[N_CHILD];

  // R7: the core request only rises after every child has completed
  assert_core_gated_R7: assert property (@(posedge clk) disable iff (!rst_q_n)
    $rose(core_req) |-> $past(all_done));
  // R4: a repeated write to a busy child never lengthens or restarts it
  assert_no_restart_R4: assert property (@(posedge clk) disable iff (!rst_q_n)
    child_req[0] && child_done[0] |=> !child_req[0]);
  // R10: while reset is held inside, no request is out
  assert_quiet_in_reset_R10: assert property (@(posedge clk)
    !rst_q_n |-> child_req == '0 && !core_req);
endmodule

// File: tb/test_srst_seq.sv
`timescale 1ns/1ps
module test_srst_seq;
  logic        clk = 1'b0;
  logic        rst_n = 1'b1;
  logic        bus_wr = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [2:0]  child_req;
  logic [2:0]  child_done = '0;
  logic        core_req;
  logic        core_done = 1'b0;

  int checks = 0;
  int errors = 0;
  bit finished = 0;
  bit tgt_on = 1;
  int cnt [4];

  // behavioural model state
  bit m_busy [4];
  bit m_seen [3];
  bit m_err;

  always #2.5 clk = ~clk;

  srst_seq i_srst_seq (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .child_req(child_req),
    .child_done(child_done), .core_req(core_req), .core_done(core_done)
  );

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      foreach (m_busy[i]) m_busy[i] = 0;
      foreach (m_seen[i]) m_seen[i] = 0;
      m_err = 0;
    end else begin
      automatic bit dn [4];
      automatic bit fin [4];
      automatic int slot = int'(bus_addr[3:2]);
      automatic bit go = bus_wr && bus_wdata[0];
      automatic bit all = m_seen[0] && m_seen[1] && m_seen[2];
      automatic bit try_core = go && slot == 3 && !m_busy[3];
      dn[0] = child_done[0]; dn[1] = child_done[1];
      dn[2] = child_done[2]; dn[3] = core_done;
      for (int i = 0; i < 4; i++) fin[i] = m_busy[i] && dn[i];
      for (int i = 0; i < 4; i++) begin
        if (m_busy[i]) m_busy[i] = !dn[i];
        else if (i < 3) m_busy[i] = go && slot == i;
        else m_busy[i] = try_core && all;
      end
      if (fin[3]) foreach (m_seen[i]) m_seen[i] = 0;
      else for (int i = 0; i < 3; i++) if (fin[i]) m_seen[i] = 1;
      if (try_core) m_err = !all;
    end
  end

  function automatic logic [31:0] model_read(int s);
    logic [31:0] v = '0;
    v[0] = m_busy[s];
    if (s == 3) v[1] = m_err;
    return v;
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic compare();
    if (!rst_n) return;
    check("R3 cycle request compare", {28'd0, core_req, child_req},
          {28'd0, m_busy[3], m_busy[2], m_busy[1], m_busy[0]});
    check("R1 cycle readback compare", bus_rdata, model_read(int'(bus_addr[3:2])));
  endtask

  task automatic step();
    bit dv [4];
    @(negedge clk);
    compare();
    bus_wr = 1'b0;
    for (int i = 0; i < 4; i++) begin
      automatic bit rq = (i < 3) ? child_req[i] : core_req;
      dv[i] = 0;
      if (tgt_on && rq) begin
        if (cnt[i] == 0) cnt[i] = $urandom_range(20, 1);
        else begin
          cnt[i]--;
          if (cnt[i] == 0) dv[i] = 1;
        end
      end
    end
    child_done = {dv[2], dv[1], dv[0]};
    core_done  = dv[3];
  endtask

  task automatic wr(int slot, logic [31:0] d);
    step();
    bus_wr = 1'b1;
    bus_addr = 4'(slot << 2);
    bus_wdata = d;
  endtask

  task automatic rd(int slot, logic [31:0] exp, string tag);
    step();
    bus_addr = 4'(slot << 2);
    #0.5;
    check(tag, bus_rdata, exp);
  endtask

  task automatic wait_idle();
    for (int k = 0; k < 200; k++) begin
      step();
      if (child_req == 3'b000 && !core_req) break;
    end
    step();
  endtask

  task automatic finish_run();
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual hung expected done");
      finish_run();
    end
  end

  initial begin
    foreach (cnt[i]) cnt[i] = 0;
    #1 rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) step();

    // R1 reset state
    for (int s = 0; s < 4; s++) rd(s, 32'd0, "R1 reset readback");
    check("R1 reset requests", {28'd0, core_req, child_req}, 32'd0);

    // R2 zero write is ignored
    wr(0, 32'hFFFF_FFFE);
    rd(0, 32'd0, "R2 zero write no effect");
    check("R2 zero write request", {31'd0, child_req[0]}, 32'd0);

    // R8 early core write rejected
    wr(3, 32'd1);
    rd(3, 32'd2, "R8 early core write sets error");
    check("R8 core request stays low", {31'd0, core_req}, 32'd0);

    // R5 any order, R4 repeated write while busy
    tgt_on = 0;
    wr(1, 32'd1);
    wr(2, 32'd1);
    rd(1, 32'd1, "R2 launch port B busy");
    check("R3 request held", {29'd0, child_req}, 32'b110);
    wr(2, 32'd1);
    rd(2, 32'd1, "R4 rewrite keeps busy");
    step(); child_done = 3'b100;
    step();
    check("R4 single done ends sequence", {29'd0, child_req}, 32'b010);
    tgt_on = 1;
    wr(0, 32'd1);
    wait_idle();
    for (int s = 0; s < 3; s++) rd(s, 32'd0, "R5 all children completed");

    // R7 accepted core write clears the error
    wr(3, 32'd1);
    rd(3, 32'd1, "R7 core accepted busy, error cleared");
    check("R7 core request high", {31'd0, core_req}, 32'd1);
    wait_idle();
    rd(3, 32'd0, "R3 core completes");

    // R9 records forgotten after core completion
    wr(3, 32'd1);
    rd(3, 32'd2, "R9 core rejected after completion");

    // R6 stray done on idle child does not count
    wr(1, 32'd1);
    wr(2, 32'd1);
    wait_idle();
    tgt_on = 0;
    step(); child_done = 3'b001;
    step();
    rd(0, 32'd0, "R6 stray done leaves idle");
    tgt_on = 1;
    wr(3, 32'd1);
    rd(3, 32'd2, "R6 stray done not recorded");

    // random traffic against the model
    for (int n = 0; n < 600; n++) begin
      if ($urandom_range(3, 0) == 0) wr($urandom_range(3, 0), 32'($urandom_range(3, 0)));
      else begin
        step();
        bus_addr = 4'($urandom_range(3, 0) << 2);
      end
    end
    wait_idle();

    // R10 asynchronous reset mid-sequence
    wr(0, 32'd1);
    wr(2, 32'd1);
    step();
    #1 rst_n = 1'b0;
    #0.5;
    check("R10 requests drop without clock", {28'd0, core_req, child_req}, 32'd0);
    foreach (cnt[i]) cnt[i] = 0;
    child_done = '0; core_done = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) step();
    for (int s = 0; s < 4; s++) rd(s, 32'd0, "R10 cleared after reset");
    wr(3, 32'd1);
    rd(3, 32'd2, "R10 records cleared by reset");
    wait_idle();
    finish_run();
  end
endmodule